// File: doc/BRIEF.md
# Flash Bus Control Decoder

This block sits at the pin boundary of a parallel NOR-style flash device. On every system clock it samples the active-low device reset, chip enable, output enable, write enable and address-valid pins, together with activity on the bus clock pin. From these it decides which kind of bus cycle is in progress. The cycle class sets the data-bus output enable, the data-input latch enable, whether the WAIT pin is driven, and a one-cycle write strobe that goes to the command logic.

The block also runs a stand-in program/erase timer. A start pulse from the command logic launches it. Standby lets the timer finish in the background, and an active-current indicator stays high until it does. Device reset stops the timer at once and marks the target location as indeterminate. When reset is released, a counted recovery interval must pass before any bus cycle is decoded or a new program/erase is accepted.

A separate power-on reset initialises the flops. The device reset pin is sampled like any other control pin.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `pin_rst_n` is low, `bus_mode` is 0 (reset). `dq_oe`, `dq_in_en`, `wait_drive` and `wr_strobe` are all 0, and a `pe_start` pulse leaves `pe_busy` at 0.
- R2: If `pin_rst_n` is sampled low while `pe_busy` is 1, then after that clock edge `pe_busy` is 0 and `pe_abort_flag` is 1. The flag stays set through reset and recovery, and the next accepted `pe_start` clears it.
- R3: After `pin_rst_n` is sampled high, `ready` stays 0 for the first `RECOV_CYC - 1` clock edges and becomes 1 at edge `RECOV_CYC`. While `ready` is 0 and the reset pin is high, `bus_mode` is 1 (recovering), no output is driven, and `pe_start` is ignored.
- R4: When the block is ready and `pin_ce_n` is high, `bus_mode` is 2 (standby) and `dq_oe` and `wait_drive` are 0, whatever the levels on the other pins.
- R5: A program/erase running when standby is entered continues on its normal schedule. `active_current` stays 1 until `pe_busy` falls and is 0 in standby afterwards. `pe_abort_flag` stays 0.
- R6: With `pin_ce_n` low, `pin_oe_n` high and `pin_we_n` high, `bus_mode` is 3 (output disable) and `dq_oe` is 0. `wait_drive` equals `cfg_admux` (1 = multiplexed mode drives WAIT deasserted, 0 = WAIT is high impedance).
- R7: With `pin_ce_n` low, `pin_oe_n` low and `pin_we_n` high, the cycle is an asynchronous read, `bus_mode` 4, when either `pin_adv_n` is high or `pin_bclk` has not toggled for more than `ACT_WIN` clock cycles. In this mode `dq_oe` and `wait_drive` are 1.
- R8: The same levels with `pin_adv_n` low while `pin_bclk` is toggling decode as a synchronous read: `bus_mode` 5, with `dq_oe` and `wait_drive` at 1.
- R9: With `pin_ce_n` low, `pin_oe_n` high and `pin_we_n` low, `bus_mode` is 6 (write), `dq_in_en` is 1, and `dq_oe` and `wait_drive` are 0.
- R10: `wr_strobe` is 1 for exactly one cycle. It rises when `pin_we_n` is back high in the cycle right after a write-class cycle, with `pin_ce_n` still low and `pin_oe_n` high. It is 0 at all other times.
- R11: With `pin_ce_n`, `pin_oe_n` and `pin_we_n` all low, `bus_mode` is 7 (conflict). Nothing is driven and no input is latched.
- R12: A `pe_start` pulse that arrives while ready, out of reset and idle holds `pe_busy` at 1 for exactly `PE_CYC` cycles. A `pe_start` that arrives while busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | Device reset pin, active low |
| pin_ce_n | input | 1 | Chip enable pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_adv_n | input | 1 | Address-valid pin, active low |
| pin_bclk | input | 1 | Bus clock pin, sampled for activity |
| cfg_admux | input | 1 | 1 = address/data multiplexed bus |
| pe_start | input | 1 | Program/erase launch pulse from command logic |
| bus_mode | output | 3 | Decoded cycle class, codes 0..7 as in R1-R11 |
| dq_oe | output | 1 | Data bus output enable |
| dq_in_en | output | 1 | Data bus input latch enable |
| wait_drive | output | 1 | WAIT pin driven (deasserted) when 1, high impedance when 0 |
| wr_strobe | output | 1 | One-cycle write-accept pulse |
| ready | output | 1 | Reset recovery interval has elapsed |
| pe_busy | output | 1 | Program/erase in progress |
| pe_abort_flag | output | 1 | Last program/erase was cut off by reset |
| active_current | output | 1 | Device is drawing active current |

## Verification
A stale recovery count shows up within one cycle as a wrong `ready` edge, and as read cycles that drive `dq_oe` too early or too late after reset release. A wrong bus-clock activity state shows up as `bus_mode` 4 where 5 is expected, or the reverse, on the first read after the clock starts or stops. A lost write-phase register shows up as a missing or doubled `wr_strobe` on the cycle after write enable rises. A program/erase timer that is off by one, or that is not cleared by reset, shows up as `pe_busy` falling on the wrong edge, or as `pe_abort_flag` at the wrong level on the edge after reset.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [2:0] {
    MODE_RESET    = 3'd0,
    MODE_RECOVER  = 3'd1,
    MODE_STANDBY  = 3'd2,
    MODE_OUTDIS   = 3'd3,
    MODE_ARD      = 3'd4,
    MODE_SRD      = 3'd5,
    MODE_WRITE    = 3'd6,
    MODE_CONFLICT = 3'd7
  } bus_mode_e;

  // Classify one sampled set of control levels.
  function automatic bus_mode_e fb_decode(input logic rst_n, input logic rdy,
                                          input logic ce_n, input logic oe_n,
                                          input logic we_n, input logic adv_n,
                                          input logic bclk_act);
    bus_mode_e m;
    if (!rst_n)                 m = MODE_RESET;
    else if (!rdy)              m = MODE_RECOVER;
    else if (ce_n)              m = MODE_STANDBY;
    else if (oe_n && we_n)      m = MODE_OUTDIS;
    else if (oe_n)              m = MODE_WRITE;
    else if (!we_n)             m = MODE_CONFLICT;
    else if (bclk_act && !adv_n) m = MODE_SRD;
    else                        m = MODE_ARD;
    return m;
  endfunction

  function automatic logic fb_is_read(input bus_mode_e m);
    return (m == MODE_ARD) || (m == MODE_SRD);
  endfunction

  function automatic logic fb_wait_on(input bus_mode_e m, input logic admux);
    return fb_is_read(m) || ((m == MODE_OUTDIS) && admux);
  endfunction

  function automatic logic fb_is_quiet(input bus_mode_e m);
    return (m == MODE_RESET) || (m == MODE_STANDBY);
  endfunction

endpackage

// File: rtl/fb_clk_activity.sv
module fb_clk_activity #(
  parameter int ACT_WIN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic bclk,
  output logic active
);
  localparam int AW = $clog2(ACT_WIN + 1);

  logic          bclk_q;
  logic [AW-1:0] idle_cnt;
  logic          toggled;

  assign toggled = bclk ^ bclk_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bclk_q   <= 1'b0;
      idle_cnt <= AW'(ACT_WIN);
    end else begin
      bclk_q <= bclk;
      if (toggled)
        idle_cnt <= '0;
      else if (idle_cnt != AW'(ACT_WIN))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign active = toggled | (idle_cnt < AW'(ACT_WIN));
endmodule

// File: rtl/fb_recovery.sv
module fb_recovery #(
  parameter int RECOV_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  output logic ready
);
  localparam int RW = $clog2(RECOV_CYC + 1);

  logic [RW-1:0] elapsed;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      elapsed <= '0;
    else if (!rst_pin_n)
      elapsed <= '0;
    else if (elapsed != RW'(RECOV_CYC))
      elapsed <= elapsed + 1'b1;
  end

  assign ready = (elapsed == RW'(RECOV_CYC));
endmodule

// File: rtl/fb_pe_engine.sv
module fb_pe_engine #(
  parameter int PE_CYC = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic accept,
  input  logic kill,
  output logic busy,
  output logic aborted,
  output logic done_evt
);
  localparam int PW = $clog2(PE_CYC + 1);

  logic [PW-1:0] remain;

  assign done_evt = busy && !kill && (remain == PW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy    <= 1'b0;
      remain  <= '0;
      aborted <= 1'b0;
    end else if (kill) begin
      if (busy) aborted <= 1'b1;
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      remain  <= PW'(PE_CYC);
      aborted <= 1'b0;
    end else if (busy) begin
      if (done_evt) begin
        busy   <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int RECOV_CYC = 8,
  parameter int PE_CYC    = 20,
  parameter int ACT_WIN   = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       pin_ce_n,
  input  logic       pin_oe_n,
  input  logic       pin_we_n,
  input  logic       pin_adv_n,
  input  logic       pin_bclk,
  input  logic       cfg_admux,
  input  logic       pe_start,
  output logic [2:0] bus_mode,
  output logic       dq_oe,
  output logic       dq_in_en,
  output logic       wait_drive,
  output logic       wr_strobe,
  output logic       ready,
  output logic       pe_busy,
  output logic       pe_abort_flag,
  output logic       active_current
);
  // named internal events, visible to the bound checker
  logic      bclk_active;
  logic      pe_accept;
  logic      pe_done;
  logic      wr_phase_q;
  bus_mode_e mode;

  fb_clk_activity #(.ACT_WIN(ACT_WIN)) act_i (
    .clk(clk), .por_n(por_n), .bclk(pin_bclk), .active(bclk_active));

  fb_recovery #(.RECOV_CYC(RECOV_CYC)) rec_i (
    .clk(clk), .por_n(por_n), .rst_pin_n(pin_rst_n), .ready(ready));

  assign pe_accept = pe_start && pin_rst_n && ready && !pe_busy;

  fb_pe_engine #(.PE_CYC(PE_CYC)) pe_i (
    .clk(clk), .por_n(por_n), .accept(pe_accept), .kill(!pin_rst_n),
    .busy(pe_busy), .aborted(pe_abort_flag), .done_evt(pe_done));

  always_comb
    mode = fb_decode(pin_rst_n, ready, pin_ce_n, pin_oe_n, pin_we_n,
                     pin_adv_n, bclk_active);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wr_phase_q <= 1'b0;
    else        wr_phase_q <= (mode == MODE_WRITE);
  end

  assign bus_mode       = mode;
  assign dq_oe          = fb_is_read(mode);
  assign dq_in_en       = (mode == MODE_WRITE);
  assign wait_drive     = fb_wait_on(mode, cfg_admux);
  assign wr_strobe      = wr_phase_q && (mode == MODE_OUTDIS);
  assign active_current = pe_busy || !fb_is_quiet(mode);
endmodule

// File: rtl/flash_bus_chk.sv
module flash_bus_chk (
  input logic       clk,
  input logic       por_n,
  input logic       pin_rst_n,
  input logic       pin_ce_n,
  input logic       pe_start,
  input logic [2:0] bus_mode,
  input logic       dq_oe,
  input logic       dq_in_en,
  input logic       wait_drive,
  input logic       wr_strobe,
  input logic       ready,
  input logic       pe_busy,
  input logic       pe_abort_flag,
  input logic       active_current,
  input logic       pe_accept
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!por_n)
    !pin_rst_n |-> (!dq_oe && !dq_in_en && !wait_drive && !wr_strobe));

  p_abort_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_rst_n && pe_busy) |=> (!pe_busy && pe_abort_flag));

  p_recover_quiet_r3: assert property (@(posedge clk) disable iff (!por_n)
    !ready |-> (!dq_oe && !dq_in_en && !wr_strobe && !pe_accept));

  p_ready_after_release_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> $past(pin_rst_n));

  p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    (pin_rst_n && pin_ce_n) |-> (!dq_oe && !wait_drive));

  p_busy_current_r5: assert property (@(posedge clk) disable iff (!por_n)
    pe_busy |-> active_current);

  p_dq_exclusive_r9: assert property (@(posedge clk) disable iff (!por_n)
    !(dq_oe && dq_in_en));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!por_n)
    wr_strobe |=> !wr_strobe);

  p_busy_from_start_r12: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pe_busy) |-> $past(pe_start));

  p_mode_range_r11: assert property (@(posedge clk) disable iff (!por_n)
    (bus_mode == 3'd7) |-> (!dq_oe && !dq_in_en));
endmodule

bind flash_bus_ctrl flash_bus_chk chk_i (
  .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .pin_ce_n(pin_ce_n),
  .pe_start(pe_start), .bus_mode(bus_mode), .dq_oe(dq_oe),
  .dq_in_en(dq_in_en), .wait_drive(wait_drive), .wr_strobe(wr_strobe),
  .ready(ready), .pe_busy(pe_busy), .pe_abort_flag(pe_abort_flag),
  .active_current(active_current), .pe_accept(pe_accept));

// File: tb/flash_bus_ctrl_tb_top.sv
module flash_bus_ctrl_tb_top;
  localparam int RECOV = 8;
  localparam int PE    = 20;
  localparam int AWIN  = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_rst_n = 1'b0, pin_ce_n = 1'b1, pin_oe_n = 1'b1, pin_we_n = 1'b1;
  logic pin_adv_n = 1'b1, pin_bclk = 1'b0, cfg_admux = 1'b0, pe_start = 1'b0;
  logic [2:0] bus_mode;
  logic dq_oe, dq_in_en, wait_drive, wr_strobe, ready, pe_busy, pe_abort_flag, active_current;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit bclk_run = 0;
  int prev_mode = 0;

  always #5 clk = ~clk;

  flash_bus_ctrl #(.RECOV_CYC(RECOV), .PE_CYC(PE), .ACT_WIN(AWIN)) dut_i (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .pin_ce_n(pin_ce_n),
    .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n), .pin_adv_n(pin_adv_n),
    .pin_bclk(pin_bclk), .cfg_admux(cfg_admux), .pe_start(pe_start),
    .bus_mode(bus_mode), .dq_oe(dq_oe), .dq_in_en(dq_in_en),
    .wait_drive(wait_drive), .wr_strobe(wr_strobe), .ready(ready),
    .pe_busy(pe_busy), .pe_abort_flag(pe_abort_flag),
    .active_current(active_current));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the cycle class, written from the requirements
  function automatic int model_mode(input bit ce, input bit oe, input bit we,
                                    input bit adv, input bit clk_on);
    int m;
    if (ce) return 2;
    case ({oe, we})
      2'b11: m = 3;
      2'b10: m = 6;
      2'b00: m = 7;
      default: m = (clk_on && !adv) ? 5 : 4;
    endcase
    return m;
  endfunction

  function automatic string req_of(input int m);
    case (m)
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  // one bus step with the block ready and out of reset
  task automatic step(input bit ce, input bit oe, input bit we, input bit adv);
    int em;
    bit rd;
    bit stb;
    @(negedge clk);
    pin_ce_n = ce; pin_oe_n = oe; pin_we_n = we; pin_adv_n = adv;
    if (bclk_run) pin_bclk = ~pin_bclk;
    #1;
    em = model_mode(ce, oe, we, adv, bclk_run);
    rd = (em == 4) || (em == 5);
    stb = (prev_mode == 6) && (em == 3);
    chk(req_of(em), bus_mode, em);
    chk(req_of(em), dq_oe, rd);
    chk(req_of(em), dq_in_en, em == 6);
    chk(req_of(em), wait_drive, rd || (em == 3 && cfg_admux));
    chk("R10", wr_strobe, stb);
    prev_mode = em;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_and_wait();
    @(negedge clk); pin_rst_n = 1'b1;
    repeat (RECOV) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int v;
    v = $urandom(32'h5eed_1234);
    // R1: power-on then device reset held low
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    pin_ce_n = 1'b0; pin_oe_n = 1'b0;
    @(negedge clk); pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0;
    #1;
    chk("R1", bus_mode, 0);
    chk("R1", dq_oe, 0);
    chk("R1", wait_drive, 0);
    chk("R1", pe_busy, 0);
    chk("R1", ready, 0);

    // R3: recovery count
    pin_ce_n = 1'b0; pin_oe_n = 1'b0; pin_we_n = 1'b1;
    @(negedge clk); pin_rst_n = 1'b1;
    repeat (RECOV - 1) @(negedge clk);
    chk("R3", ready, 0);
    chk("R3", bus_mode, 1);
    chk("R3", dq_oe, 0);
    pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0;
    chk("R3", ready, 1);
    chk("R3", pe_busy, 0);
    chk("R7", bus_mode, 4);

    // R12: program/erase duration, restart while busy ignored
    pin_ce_n = 1'b1; pin_oe_n = 1'b1;
    @(negedge clk); pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0;
    chk("R12", pe_busy, 1);
    for (int k = 1; k < PE; k++) begin
      if (k == 5) pe_start = 1'b1;
      @(negedge clk);
      pe_start = 1'b0;
      chk("R12", pe_busy, 1);
    end
    @(negedge clk);
    chk("R12", pe_busy, 0);
    chk("R12", active_current, 0);

    // R5: standby entered mid-operation
    pin_ce_n = 1'b0; pin_oe_n = 1'b1;
    pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0; pin_ce_n = 1'b1; pin_oe_n = 1'b0;
    #1;
    chk("R5", bus_mode, 2);
    chk("R5", dq_oe, 0);
    for (int k = 1; k < PE; k++) begin
      @(negedge clk);
      chk("R5", pe_busy, 1);
      chk("R5", active_current, 1);
    end
    @(negedge clk);
    chk("R5", pe_busy, 0);
    chk("R5", active_current, 0);
    chk("R5", pe_abort_flag, 0);

    // R2: reset asserted mid-operation
    @(negedge clk); pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0;
    idle_cycles(3);
    pin_rst_n = 1'b0;
    @(negedge clk);
    chk("R2", pe_busy, 0);
    chk("R2", pe_abort_flag, 1);
    chk("R1", bus_mode, 0);
    release_and_wait();
    chk("R2", pe_abort_flag, 1);
    chk("R3", ready, 1);
    pe_start = 1'b1;
    @(negedge clk); pe_start = 1'b0;
    chk("R2", pe_abort_flag, 0);
    chk("R12", pe_busy, 1);
    idle_cycles(PE + 1);

    // directed: write then strobe, conflict, output disable
    prev_mode = 2;
    bclk_run = 0;
    cfg_admux = 1'b1;
    step(0, 1, 0, 1);
    step(0, 1, 0, 1);
    step(0, 1, 1, 1);
    step(0, 1, 1, 1);
    step(0, 0, 0, 1);
    step(0, 1, 0, 1);
    step(1, 1, 1, 1);

    // constrained random segments
    for (int seg = 0; seg < 40; seg++) begin
      bclk_run = ($urandom % 2) == 1;
      cfg_admux = ($urandom % 2) == 1;
      if (!bclk_run) begin
        @(negedge clk); pin_ce_n = 1'b1;
        idle_cycles(AWIN + 3);
        prev_mode = 2;
      end
      for (int i = 0; i < 25; i++) begin
        v = $urandom % 16;
        step(v[3] && v[2], v[1], v[0] | (v[2] & ~v[3]), v[2]);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule